// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a segment:offset memory reference into a 20-bit linear address, in the way a 16-bit real-mode processor forms one. A request carries an addressing-mode code, a 16-bit constant, selectors for a base and an index general register, a scale code, an optional segment override and the current instruction pointer. The six 16-bit segment registers and eight 32-bit general registers arrive as flat input vectors, so the block holds no architectural state of its own.

The block first folds the selected operands into one 16-bit effective address (EA). It then picks a segment, shifts that segment's value left by four bits, and adds the EA to form the linear address. Each response carries the EA, the segment code that was used and the linear address. Requests and responses each use a ready/valid handshake, with one register stage between them. An illegal request produces a one-cycle error pulse in place of a valid response.

Top module: `seg_addr_gen`

## Requirements
- R1: The linear address is ((segment value × 16) + EA) modulo 2^20. For example, 1234h:0022h gives 12362h and FFFFh:0010h gives 00000h.
- R2: Only the low 16 bits of a general register take part in the EA. The EA sum is truncated to 16 bits, so an overflowing offset wraps within the segment.
- R3: Mode codes and their EA formulas:
  - 0: EA = constant.
  - 1: EA = base.
  - 2: EA = base + index.
  - 3: EA = base + constant.
  - 4: EA = base + index + constant.
  - 5: EA = base + scale × index.
  - 6: instruction fetch.
  - 7: illegal.
- R4: Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R5: General register codes are 0 AX, 1 CX, 2 DX, 3 BX, 4 SP, 5 BP, 6 SI, 7 DI. Segment codes are 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS. With no override, the segment is SS (code 2) when SP or BP is a base or index operand of the mode. Otherwise it is DS (code 3).
- R6: When the override enable is set, the override segment code replaces the default segment.
- R7: Mode 6 always uses CS (code 1) with the instruction pointer input as the EA, whatever the override fields hold.
- R8: A request is illegal in any of these cases:
  - mode 7;
  - mode 2 or 4 with a base other than BX or BP, or an index other than SI or DI;
  - an enabled override with code 6 or 7 (not checked in mode 6).
  An illegal request raises rsp_err for exactly the cycle after acceptance. It does not raise rsp_valid and leaves the response data unchanged.
- R9: req_ready is high when no response is pending or rsp_ready is high. An accepted legal request shows rsp_valid one clock later. While rsp_valid is high and rsp_ready is low, the response holds stable.
- R10: After reset, rsp_valid and rsp_err are low and rsp_ea, rsp_seg and rsp_lin are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_mode | input | 3 | Addressing-mode code |
| req_disp | input | 16 | Constant operand |
| req_base | input | 3 | Base register code |
| req_idx | input | 3 | Index register code |
| req_scale | input | 2 | Scale code |
| req_ovr_en | input | 1 | Segment override enable |
| req_ovr_seg | input | 3 | Override segment code |
| req_ip | input | 16 | Instruction pointer |
| seg_regs | input | 96 | Segment registers, code n in bits [16n+15:16n] |
| gpr_regs | input | 256 | General registers, code n in bits [32n+31:32n] |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | Illegal-request pulse |
| rsp_ea | output | 16 | Effective address |
| rsp_seg | output | 3 | Segment code used |
| rsp_lin | output | 20 | Linear address |

## Verification
A wrong segment choice or a wrong EA term shows in rsp_seg, rsp_ea or rsp_lin. It appears on the first response after the offending request is accepted, which is one clock later. A fault in the pending-response state shows as a wrong req_ready, or as a response that changes during a stall, in the same cycle the fault occurs. An error flag that lingers shows one cycle after the illegal request. The bench's model follows the handshake every cycle, so each of these is seen on the first clock on which it differs.

// File: rtl/seg_addr_gen.sv
`timescale 1ns/1ps
module seg_addr_gen #(
  parameter int SEGW = 16,
  parameter int GPRW = 32,
  parameter int OFFW = 16,
  parameter int NSEG = 6,
  parameter int NGPR = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [2:0]           req_mode,
  input  logic [OFFW-1:0]      req_disp,
  input  logic [2:0]           req_base,
  input  logic [2:0]           req_idx,
  input  logic [1:0]           req_scale,
  input  logic                 req_ovr_en,
  input  logic [2:0]           req_ovr_seg,
  input  logic [OFFW-1:0]      req_ip,
  input  logic [NSEG*SEGW-1:0] seg_regs,
  input  logic [NGPR*GPRW-1:0] gpr_regs,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic                 rsp_err,
  output logic [OFFW-1:0]      rsp_ea,
  output logic [2:0]           rsp_seg,
  output logic [SEGW+3:0]      rsp_lin
);
  localparam int LINW = SEGW + 4;
  localparam logic [2:0] S_CS = 3'd1, S_SS = 3'd2, S_DS = 3'd3;
  localparam logic [2:0] G_SP = 3'd4, G_BX = 3'd3, G_BP = 3'd5, G_SI = 3'd6, G_DI = 3'd7;

  logic [OFFW-1:0] base_v, idx_v, scaled_v, ea;
  logic [2:0]      seg_sel, seg_ix;
  logic            stk, legal, pair_ok;
  logic [SEGW-1:0] seg_v;

  assign base_v   = gpr_regs[req_base*GPRW +: OFFW];
  assign idx_v    = gpr_regs[req_idx*GPRW +: OFFW];
  assign scaled_v = idx_v << req_scale;
  assign pair_ok  = (req_base == G_BX || req_base == G_BP) && (req_idx == G_SI || req_idx == G_DI);

  always_comb begin
    ea    = '0;
    stk   = 1'b0;
    legal = 1'b1;
    case (req_mode)
      3'd0: ea = req_disp;
      3'd1: begin ea = base_v;            stk = (req_base == G_SP || req_base == G_BP); end
      3'd2: begin ea = base_v + idx_v;    stk = (req_base == G_BP); legal = pair_ok; end
      3'd3: begin ea = base_v + req_disp; stk = (req_base == G_SP || req_base == G_BP); end
      3'd4: begin ea = base_v + idx_v + req_disp; stk = (req_base == G_BP); legal = pair_ok; end
      3'd5: begin
        ea  = base_v + scaled_v;
        stk = (req_base == G_SP || req_base == G_BP || req_idx == G_SP || req_idx == G_BP);
      end
      3'd6: ea = req_ip;
      default: legal = 1'b0;
    endcase
    if (req_mode == 3'd6)
      seg_sel = S_CS;
    else if (req_ovr_en) begin
      seg_sel = req_ovr_seg;
      if (int'(req_ovr_seg) >= NSEG) legal = 1'b0;
    end else
      seg_sel = stk ? S_SS : S_DS;
  end

  assign seg_ix    = (int'(seg_sel) < NSEG) ? seg_sel : 3'd0;
  assign seg_v     = seg_regs[seg_ix*SEGW +: SEGW];
  assign req_ready = !rsp_valid || rsp_ready;

  wire fire = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_ea    <= '0;
      rsp_seg   <= '0;
      rsp_lin   <= '0;
    end else begin
      rsp_err <= fire && !legal;
      if (fire) begin
        rsp_valid <= legal;
        if (legal) begin
          rsp_ea  <= ea;
          rsp_seg <= seg_sel;
          rsp_lin <= {seg_v, 4'h0} + LINW'(ea);
        end
      end else if (rsp_ready)
        rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/seg_addr_gen_chk.sv
`timescale 1ns/1ps
module seg_addr_gen_chk #(
  parameter int SEGW = 16,
  parameter int GPRW = 32,
  parameter int OFFW = 16,
  parameter int NSEG = 6,
  parameter int NGPR = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 req_valid,
  input logic                 req_ready,
  input logic [2:0]           req_mode,
  input logic [OFFW-1:0]      req_disp,
  input logic [2:0]           req_base,
  input logic                 req_ovr_en,
  input logic [OFFW-1:0]      req_ip,
  input logic [NSEG*SEGW-1:0] seg_regs,
  input logic                 rsp_valid,
  input logic                 rsp_ready,
  input logic                 rsp_err,
  input logic [OFFW-1:0]      rsp_ea,
  input logic [2:0]           rsp_seg,
  input logic [SEGW+3:0]      rsp_lin
);
  wire fire = req_valid && req_ready;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_lin) && $stable(rsp_ea) && $stable(rsp_seg));

  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> $past(fire) && !rsp_valid);

  p_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_mode == 3'd6 |=> rsp_valid && rsp_seg == 3'd1 && rsp_ea == $past(req_ip));

  p_direct_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_mode == 3'd0 && !req_ovr_en |=>
      rsp_lin == {$past(seg_regs[3*SEGW +: SEGW]), 4'h0} + (SEGW+4)'($past(req_disp)));

  p_stack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire && req_mode == 3'd1 && !req_ovr_en && (req_base == 3'd4 || req_base == 3'd5) |=>
      rsp_seg == 3'd2);
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEGW(SEGW), .GPRW(GPRW), .OFFW(OFFW), .NSEG(NSEG), .NGPR(NGPR)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
  .req_disp(req_disp), .req_base(req_base), .req_ovr_en(req_ovr_en), .req_ip(req_ip),
  .seg_regs(seg_regs), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
  .rsp_ea(rsp_ea), .rsp_seg(rsp_seg), .rsp_lin(rsp_lin));

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, rsp_valid, rsp_ready = 1, rsp_err, req_ovr_en = 0;
  logic [2:0] req_mode = 0, req_base = 0, req_idx = 0, req_ovr_seg = 0, rsp_seg;
  logic [1:0] req_scale = 0;
  logic [15:0] req_disp = 0, req_ip = 0, rsp_ea;
  logic [19:0] rsp_lin;
  logic [15:0] segr [6];
  logic [31:0] gpr [8];
  logic [95:0] seg_flat;
  logic [255:0] gpr_flat;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 6; i++) seg_flat[i*16 +: 16] = segr[i];
    for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = gpr[i];
  end

  seg_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_mode(req_mode),
    .req_disp(req_disp), .req_base(req_base), .req_idx(req_idx), .req_scale(req_scale),
    .req_ovr_en(req_ovr_en), .req_ovr_seg(req_ovr_seg), .req_ip(req_ip), .seg_regs(seg_flat),
    .gpr_regs(gpr_flat), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_ea(rsp_ea), .rsp_seg(rsp_seg), .rsp_lin(rsp_lin));

  int ncmp = 0, nbad = 0, cycles = 0;
  string cur_tag = "R3", m_tag = "R10";
  bit m_valid = 0, m_err = 0;
  int m_ea = 0, m_seg = 0, m_lin = 0;

  task automatic chk(input string tag, input int act, input int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void calc(output bit ok, output int ea, output int sg, output int lin);
    int b, x, d;
    bit stk;
    b = gpr[req_base] & 'hFFFF;
    x = gpr[req_idx] & 'hFFFF;
    d = req_disp;
    ok = 1; stk = 0; ea = 0;
    case (req_mode)
      0: ea = d;
      1: begin ea = b; stk = req_base inside {4, 5}; end
      2: begin ea = b + x; stk = req_base == 5; ok = (req_base inside {3, 5}) && (req_idx inside {6, 7}); end
      3: begin ea = b + d; stk = req_base inside {4, 5}; end
      4: begin ea = b + x + d; stk = req_base == 5; ok = (req_base inside {3, 5}) && (req_idx inside {6, 7}); end
      5: begin ea = b + x * (1 << req_scale); stk = (req_base inside {4, 5}) || (req_idx inside {4, 5}); end
      6: ea = req_ip;
      default: ok = 0;
    endcase
    ea = ea % 65536;
    if (req_mode == 6) sg = 1;
    else if (req_ovr_en) begin sg = req_ovr_seg; if (sg > 5) ok = 0; end
    else sg = stk ? 2 : 3;
    lin = (sg < 6) ? ((segr[sg] * 16 + ea) % (1 << 20)) : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_err = 0; m_ea = 0; m_seg = 0; m_lin = 0;
    end else begin
      bit fire, ok;
      int e, s, l;
      fire = req_valid && (!m_valid || rsp_ready);
      calc(ok, e, s, l);
      m_err = fire && !ok;
      if (fire) begin
        m_valid = ok;
        if (ok) begin m_ea = e; m_seg = s; m_lin = l; m_tag = cur_tag; end
      end else if (rsp_ready) m_valid = 0;
    end
  end

  always @(negedge clk) begin
    cycles++;
    chk("R9 req_ready", int'(req_ready), int'(!m_valid || rsp_ready));
    chk("R9 rsp_valid", int'(rsp_valid), int'(m_valid));
    chk("R8 rsp_err", int'(rsp_err), int'(m_err));
    chk({m_tag, " rsp_lin"}, int'(rsp_lin), m_lin);
    chk({m_tag, " rsp_ea"}, int'(rsp_ea), m_ea);
    chk({m_tag, " rsp_seg"}, int'(rsp_seg), m_seg);
    if (cycles > 50000) begin
      nbad++;
      $display("FAIL watchdog: actual %0d cycles expected below 50000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  task automatic issue(input string tag, input int m, input int d, input int b, input int x,
                       input int sc, input bit oe, input int os, input bit xerr, input int xlin);
    cur_tag = tag;
    req_mode = 3'(m); req_disp = 16'(d); req_base = 3'(b); req_idx = 3'(x);
    req_scale = 2'(sc); req_ovr_en = oe; req_ovr_seg = 3'(os); req_valid = 1;
    @(negedge clk);
    if (xerr) begin
      chk({tag, " err pulse"}, int'(rsp_err), 1);
      chk({tag, " no valid"}, int'(rsp_valid), 0);
    end else begin
      chk({tag, " direct lin"}, int'(rsp_lin), xlin);
    end
    #1 req_valid = 0;
  endtask

  initial begin
    segr = '{16'h4000, 16'h1000, 16'h2000, 16'h3000, 16'h5000, 16'h6000};
    gpr = '{32'h0, 32'h0, 32'h0, 32'hABCD1234, 32'h0002FF00, 32'h0000F000, 32'h0001000E, 32'h0};
    req_ip = 16'h0100;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", int'(rsp_valid), 0);
    chk("R10 reset lin", int'(rsp_lin), 0);
    #1 rst_n = 1;
    @(negedge clk); #1;
    issue("R7", 6, 0, 0, 0, 0, 1, 0, 0, 'h10100);
    issue("R5", 1, 0, 4, 0, 0, 0, 0, 0, 'h2FF00);
    issue("R5", 1, 0, 5, 0, 0, 0, 0, 0, 'h2F000);
    issue("R2", 1, 0, 6, 0, 0, 0, 0, 0, 'h3000E);
    issue("R6", 1, 0, 3, 0, 0, 1, 0, 0, 'h41234);
    segr[3] = 16'h1234;
    issue("R1", 0, 'h0022, 0, 0, 0, 0, 0, 0, 'h12362);
    segr[3] = 16'hFFFF;
    issue("R1", 0, 'h0010, 0, 0, 0, 0, 0, 0, 'h00000);
    segr[3] = 16'h3000;
    gpr[3] = 32'h7777FFFF;
    issue("R2", 3, 2, 3, 0, 0, 0, 0, 0, 'h30001);
    gpr[3] = 32'h10; gpr[6] = 32'h3;
    issue("R4", 5, 0, 3, 6, 3, 0, 0, 0, 'h30028);
    issue("R3", 4, 'h10, 3, 6, 0, 0, 0, 0, 'h30023);
    issue("R8", 7, 0, 0, 0, 0, 0, 0, 1, 0);
    issue("R8", 2, 0, 0, 6, 0, 0, 0, 1, 0);
    issue("R8", 1, 0, 3, 0, 0, 1, 6, 1, 0);
    chk("R8 data kept", int'(rsp_lin), 'h30028 + 'h3 - 'h3 + 'h10 - 'h15);
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < 6; i++) segr[i] = 16'($urandom);
      for (int i = 0; i < 8; i++) gpr[i] = $urandom;
      req_mode = 3'($urandom); req_disp = 16'($urandom);
      req_base = 3'($urandom); req_idx = 3'($urandom); req_scale = 2'($urandom);
      if (req_mode inside {2, 4} && $urandom_range(0, 3) != 0) begin
        req_base = $urandom_range(0, 1) ? 3'd3 : 3'd5;
        req_idx = $urandom_range(0, 1) ? 3'd6 : 3'd7;
      end
      req_ovr_en = ($urandom_range(0, 3) == 0);
      req_ovr_seg = 3'($urandom_range(0, 6));
      req_ip = 16'($urandom);
      req_valid = ($urandom_range(0, 3) != 0);
      rsp_ready = ($urandom_range(0, 3) != 0);
      cur_tag = (req_mode == 5) ? "R4" : (req_mode == 6) ? "R7" : req_ovr_en ? "R6" : "R3";
      @(negedge clk); #1;
    end
    req_valid = 0; rsp_ready = 1;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule